// File: doc/BRIEF.md
# Maskable Interrupt Vector Arbiter

The block takes up to 64 interrupt request lines. Each line is either a level source, which is pending only while its input is high, or an edge source, which latches a pending flag on a rising edge. The source positions are fixed in hardware. Vectors 16 and 21 are level sources. Vectors 23 and 28 to 31 are edge sources. Every other vector is reserved, and a reserved vector can never raise a request.

Each pending source is gated by an enable bit and by a 4-bit priority level. The block picks the strongest pending source and holds its vector number until the processor acknowledges it. It also presents the address from which the handler pointer is fetched, computed from a programmable table base. A separate non-maskable input takes precedence over all of this and points the fetch address at a fixed location.

Software programs the base, enable and priority registers through a simple write port. The port selector picks the register kind: 0 is the table base, 1 is an enable register and 2 is a priority register. The acknowledge input retires the request that is currently presented.

Top module: `vec_arbiter`

## Requirements
- R1: After reset, `irq_req` and `nmi_req` are 0 and `fetch_addr` is 0.
- R2: A write with `wr_sel`=0 loads the table base with its two low bits forced to 0. While no non-maskable request is pending, `fetch_addr` equals the base plus 4 × `irq_vec`.
- R3: Vectors 16 and 21 are level sources. They are candidates only in cycles where their input is 1, so after an acknowledge a source whose input is still high is requested again, and one whose input is low is not.
- R4: Vectors 23 and 28–31 are edge sources. A 0→1 input change latches a pending flag, even for a one-cycle pulse. Acknowledging that vector clears the flag, except that a rising edge in the same cycle sets it again.
- R5: Writing `wr_sel`=1 with `wr_idx`=k loads enable register k from `wr_data[7:0]`. The enable for vector n is bit n mod 8 of register n div 8, and a source whose enable is 0 is never requested.
- R6: Reserved vectors never produce a request, whatever their inputs and enable bits are.
- R7: Writing `wr_sel`=2 with `wr_idx`=k loads priority register k from `wr_data[3:0]`. Vectors 16, 21 and 23 use registers 0, 1 and 2, and vectors 28–31 use registers 4–7. Level 0 disables a source, and a higher level is selected first.
- R8: Among candidates with equal levels, the lowest vector number is selected.
- R9: A maskable request is raised only when the selected level is strictly greater than `cpu_ipl`.
- R10: While `irq_req` is 1 and `ack` is 0, both `irq_req` and `irq_vec` keep their values, even when a stronger source arrives.
- R11: A rising edge on `nmi_in` sets `nmi_req`, which forces `fetch_addr` to `NMI_ADDR`. While `nmi_req` is 1, `ack` clears only `nmi_req` and leaves any held maskable request in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NVEC | Request lines, one per vector number |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register kind: 0 base, 1 enable, 2 priority |
| wr_idx | input | 8 | Register index for enable and priority writes |
| wr_data | input | AW | Write data |
| cpu_ipl | input | PW | Current processor mask level |
| ack | input | 1 | Acknowledge of the presented request |
| nmi_in | input | 1 | Non-maskable request line |
| irq_req | output | 1 | Maskable request to the processor |
| irq_vec | output | 8 | Held vector number |
| fetch_addr | output | AW | Vector fetch address |
| nmi_req | output | 1 | Pending non-maskable request |

## Verification
Two situations are hard to reach from the ports. The first is an acknowledge that lands in the same cycle as a fresh rising edge on the vector being retired. The second is a non-maskable edge that arrives while a maskable request is held, followed by an acknowledge that must retire only the non-maskable one.

The directed phases reach the second situation on purpose: a request is held, a pulse is sent on `nmi_in`, and the acknowledge comes next. A long pseudo-random phase then toggles the edge lines, pulses `nmi_in` and acknowledges at random. This lands acknowledges on top of edges and overlaps both kinds of request many times. A behavioural model checks every cycle of the run.

// File: rtl/vec_arbiter.sv
module vec_arbiter #(
  parameter int NVEC = 64,
  parameter int AW = 32,
  parameter int PW = 4,
  parameter int NPRI = 8,
  parameter logic [31:0] NMI_ADDR = 32'hFFFF_FFF8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] irq_in,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [7:0]      wr_idx,
  input  logic [AW-1:0]   wr_data,
  input  logic [PW-1:0]   cpu_ipl,
  input  logic            ack,
  input  logic            nmi_in,
  output logic            irq_req,
  output logic [7:0]      irq_vec,
  output logic [AW-1:0]   fetch_addr,
  output logic            nmi_req
);
  localparam int NEREG = NVEC / 8;

  function automatic logic is_lvl(int v);
    return v == 16 || v == 21;
  endfunction

  function automatic logic is_edg(int v);
    return v == 23 || (v >= 28 && v <= 31);
  endfunction

  function automatic int pri_of(int v);
    case (v)
      16: return 0;
      21: return 1;
      23: return 2;
      28, 29, 30, 31: return v - 24;
      default: return 0;
    endcase
  endfunction

  logic [AW-1:0]   base_q;
  logic [7:0]      en_q [NEREG];
  logic [PW-1:0]   pri_q [NPRI];
  logic [NVEC-1:0] prev_q, epend_q, live;
  logic            nmi_prev_q;
  logic [PW-1:0]   best_lvl;
  logic [7:0]      best_vec;
  logic            take_ack;

  always_comb begin
    for (int v = 0; v < NVEC; v++) begin
      if (is_lvl(v))      live[v] = irq_in[v] & en_q[v / 8][v % 8];
      else if (is_edg(v)) live[v] = epend_q[v] & en_q[v / 8][v % 8];
      else                live[v] = 1'b0;
    end
  end

  always_comb begin
    best_lvl = '0;
    best_vec = '0;
    for (int v = 0; v < NVEC; v++) begin
      if (live[v] && pri_q[pri_of(v)] > best_lvl) begin
        best_lvl = pri_q[pri_of(v)];
        best_vec = 8'(v);
      end
    end
  end

  assign take_ack   = ack && irq_req && !nmi_req;
  assign fetch_addr = nmi_req ? AW'(NMI_ADDR) : base_q + (AW'(irq_vec) << 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      prev_q     <= '0;
      epend_q    <= '0;
      nmi_prev_q <= 1'b0;
      nmi_req    <= 1'b0;
      irq_req    <= 1'b0;
      irq_vec    <= '0;
      for (int i = 0; i < NEREG; i++) en_q[i] <= '0;
      for (int i = 0; i < NPRI; i++)  pri_q[i] <= '0;
    end else begin
      prev_q     <= irq_in;
      nmi_prev_q <= nmi_in;
      nmi_req    <= (nmi_req & ~ack) | (nmi_in & ~nmi_prev_q);
      for (int v = 0; v < NVEC; v++) begin
        if (is_edg(v))
          epend_q[v] <= (epend_q[v] & ~(take_ack && irq_vec == 8'(v))) | (irq_in[v] & ~prev_q[v]);
        else
          epend_q[v] <= 1'b0;
      end
      if (take_ack) irq_req <= 1'b0;
      else if (!irq_req && best_lvl > cpu_ipl) begin
        irq_req <= 1'b1;
        irq_vec <= best_vec;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: base_q <= {wr_data[AW-1:2], 2'b00};
          2'd1: if (int'(wr_idx) < NEREG) en_q[wr_idx] <= wr_data[7:0];
          2'd2: if (int'(wr_idx) < NPRI) pri_q[wr_idx] <= wr_data[PW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vec_arbiter_chk.sv
module vec_arbiter_chk #(
  parameter int AW = 32,
  parameter logic [31:0] NMI_ADDR = 32'hFFFF_FFF8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          irq_req,
  input logic [7:0]    irq_vec,
  input logic [AW-1:0] fetch_addr,
  input logic          nmi_req
);
  a_r10_hold_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !ack |=> irq_req && irq_vec == $past(irq_vec));

  a_r6_active_only: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == 8'd16 || irq_vec == 8'd21 || irq_vec == 8'd23 ||
                 (irq_vec >= 8'd28 && irq_vec <= 8'd31)));

  a_r11_nmi_addr: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> fetch_addr == AW'(NMI_ADDR));

  a_r11_ack_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req && ack && irq_req |=> irq_req);

  a_r4_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && ack && !nmi_req |=> !irq_req);
endmodule

bind vec_arbiter vec_arbiter_chk #(.AW(AW), .NMI_ADDR(NMI_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .irq_req(irq_req),
  .irq_vec(irq_vec), .fetch_addr(fetch_addr), .nmi_req(nmi_req));

// File: tb/sim_vec_arbiter.sv
`timescale 1ns/1ps
module sim_vec_arbiter;
  localparam int NV = 64;
  localparam logic [31:0] NMIA = 32'hFFFF_FFF8;

  logic clk = 0, rst_n = 0;
  logic [NV-1:0] irq_in = '0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic [3:0] cpu_ipl = 0;
  logic ack = 0, nmi_in = 0;
  logic irq_req, nmi_req;
  logic [7:0] irq_vec;
  logic [31:0] fetch_addr;

  vec_arbiter u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data), .cpu_ipl(cpu_ipl), .ack(ack), .nmi_in(nmi_in),
    .irq_req(irq_req), .irq_vec(irq_vec), .fetch_addr(fetch_addr), .nmi_req(nmi_req));

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference
  bit [31:0] m_base;
  bit [7:0] m_en [8];
  int m_pri [8];
  bit m_pend [NV], m_prev [NV];
  bit m_req, m_nmi, m_nprev;
  int m_vec;

  function automatic int kind(int v);
    if (v == 16 || v == 21) return 1;
    if (v == 23 || (v >= 28 && v <= 31)) return 2;
    return 0;
  endfunction
  function automatic int slot(int v);
    if (v == 16) return 0;
    if (v == 21) return 1;
    if (v == 23) return 2;
    return v - 24;
  endfunction

  always @(posedge clk) begin
    int bl, bv; bit tack, nn;
    if (!rst_n) begin
      m_base = 0; m_req = 0; m_nmi = 0; m_nprev = 0; m_vec = 0;
      foreach (m_en[i]) m_en[i] = 0;
      foreach (m_pri[i]) m_pri[i] = 0;
      foreach (m_pend[i]) begin m_pend[i] = 0; m_prev[i] = 0; end
    end else begin
      bl = 0; bv = 0;
      for (int v = 0; v < NV; v++) begin
        bit on;
        on = (kind(v) == 1) ? irq_in[v] : (kind(v) == 2) ? m_pend[v] : 1'b0;
        if (on && m_en[v/8][v%8] && m_pri[slot(v)] > bl) begin bl = m_pri[slot(v)]; bv = v; end
      end
      tack = ack && m_req && !m_nmi;
      nn = (m_nmi && !ack) || (nmi_in && !m_nprev);
      for (int v = 0; v < NV; v++)
        if (kind(v) == 2)
          m_pend[v] = (m_pend[v] && !(tack && m_vec == v)) || (irq_in[v] && !m_prev[v]);
      if (tack) m_req = 0;
      else if (!m_req && bl > int'(cpu_ipl)) begin m_req = 1; m_vec = bv; end
      m_nmi = nn; m_nprev = nmi_in;
      for (int v = 0; v < NV; v++) m_prev[v] = irq_in[v];
      if (wr_en) begin
        if (wr_sel == 0) m_base = wr_data & ~32'h3;
        else if (wr_sel == 1 && wr_idx < 8) m_en[wr_idx] = wr_data[7:0];
        else if (wr_sel == 2 && wr_idx < 8) m_pri[wr_idx] = int'(wr_data[3:0]);
      end
    end
  end

  always @(negedge clk) begin
    bit [31:0] ea;
    if (rst_n && !done) begin
      ea = m_nmi ? NMIA : m_base + 32'(m_vec) * 4;
      tests++;
      if (irq_req !== m_req || nmi_req !== m_nmi || fetch_addr !== ea ||
          (m_req && irq_vec !== 8'(m_vec))) begin
        fails++;
        $display("FAIL %s model: req=%0b vec=%0d nmi=%0b addr=%h expected req=%0b vec=%0d nmi=%0b addr=%h",
                 tag, irq_req, irq_vec, nmi_req, fetch_addr, m_req, m_vec, m_nmi, ea);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wr(int s, int i, int d);
    wr_en = 1; wr_sel = 2'(s); wr_idx = 8'(i); wr_data = 32'(d); tick(); wr_en = 0;
  endtask
  task automatic pulse_ack();
    ack = 1; tick(); ack = 0;
  endtask
  task automatic expect_v(string t, int act, int exp);
    tests++;
    if (act != exp) begin fails++; $display("FAIL %s actual=%0h expected=%0h", t, act, exp); end
  endtask

  initial begin
    tick(2); rst_n = 1; #1;
    tag = "R1";
    expect_v("R1 req", int'(irq_req), 0);
    expect_v("R1 addr", int'(fetch_addr), 0);
    expect_v("R1 nmi", int'(nmi_req), 0);
    tick(2);
    tag = "R2";
    wr(0, 0, 32'h1003); wr(2, 0, 5); wr(1, 2, 8'h01);
    irq_in[16] = 1; tick();
    expect_v("R2 vec", int'(irq_vec), 16);
    expect_v("R2 addr", int'(fetch_addr), 32'h1040);
    tag = "R3";
    pulse_ack(); tick();
    expect_v("R3 level rerequest", int'(irq_req), 1);
    irq_in[16] = 0; pulse_ack(); tick();
    expect_v("R3 level dropped", int'(irq_req), 0);
    tag = "R4";
    wr(2, 4, 3); wr(1, 3, 8'h10);
    irq_in[28] = 1; tick(); irq_in[28] = 0; tick();
    expect_v("R4 edge latched", int'(irq_req), 1);
    expect_v("R4 vec", int'(irq_vec), 28);
    pulse_ack(); tick();
    expect_v("R4 ack clears", int'(irq_req), 0);
    tag = "R5";
    wr(1, 3, 0); wr(2, 5, 6);
    irq_in[29] = 1; tick(); irq_in[29] = 0; tick(2);
    expect_v("R5 disabled", int'(irq_req), 0);
    wr(1, 3, 8'h20); tick();
    expect_v("R5 enabled vec", int'(irq_vec), 29);
    pulse_ack(); tick();
    tag = "R6";
    for (int i = 0; i < 8; i++) wr(1, i, 8'hFF);
    for (int v = 0; v < NV; v++) if (kind(v) == 0) irq_in[v] = 1;
    tick(3);
    expect_v("R6 reserved", int'(irq_req), 0);
    irq_in = '0; tick();
    for (int v = 0; v < NV; v++) if (kind(v) == 0) irq_in[v] = 1;
    tick(2);
    expect_v("R6 reserved edge", int'(irq_req), 0);
    irq_in = '0;
    tag = "R8";
    wr(2, 0, 2); wr(2, 1, 2);
    irq_in[16] = 1; irq_in[21] = 1; tick();
    expect_v("R8 tie low vector", int'(irq_vec), 16);
    tag = "R7";
    wr(2, 1, 7); pulse_ack(); tick();
    expect_v("R7 higher level", int'(irq_vec), 21);
    wr(2, 1, 0); pulse_ack(); tick();
    expect_v("R7 level zero off", int'(irq_vec), 16);
    irq_in = '0; pulse_ack(); tick();
    tag = "R9";
    cpu_ipl = 5; wr(2, 0, 5); irq_in[16] = 1; tick(2);
    expect_v("R9 masked", int'(irq_req), 0);
    cpu_ipl = 4; tick();
    expect_v("R9 above mask", int'(irq_req), 1);
    irq_in = '0; pulse_ack(); cpu_ipl = 0; tick();
    tag = "R10";
    wr(2, 0, 1); irq_in[16] = 1; tick();
    wr(2, 1, 9); irq_in[21] = 1; tick(3);
    expect_v("R10 held vec", int'(irq_vec), 16);
    pulse_ack(); tick();
    expect_v("R10 next vec", int'(irq_vec), 21);
    tag = "R11";
    nmi_in = 1; tick(); nmi_in = 0;
    expect_v("R11 nmi set", int'(nmi_req), 1);
    expect_v("R11 nmi addr", int'(fetch_addr), int'(NMIA));
    pulse_ack();
    expect_v("R11 nmi cleared", int'(nmi_req), 0);
    expect_v("R11 maskable kept", int'(irq_req), 1);
    irq_in = '0; pulse_ack(); tick();
    tag = "R4 R8 R11 random";
    begin
      int s = 32'h1ACE5;
      for (int i = 0; i < 8; i++) wr(2, i, i % 4);
      for (int n = 0; n < 4000; n++) begin
        s = s ^ (s << 13); s = s ^ (s >>> 17); s = s ^ (s << 5);
        irq_in[16] = s[0]; irq_in[21] = s[1]; irq_in[23] = s[2];
        irq_in[31:28] = s[6:3]; irq_in[9] = s[7];
        nmi_in = (s[12:8] == 0);
        ack = s[13] & s[14];
        cpu_ipl = 4'(s[16:15]);
        wr_en = (s[21:17] == 0); wr_sel = 2; wr_idx = 8'(s[24:22]); wr_data = 32'(s[28:25]);
        tick();
      end
      wr_en = 0; ack = 0; nmi_in = 0;
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule